// File: doc/BRIEF.md
# Scaled-Add Integer ALU

This block is a registered 32-bit integer ALU with no multiplier. Its operation set holds add, subtract, variable left shift, negate and three fused operations that shift the first operand left by one, two or three places and then add the second. With these, a multiply by any constant can be written as a short chain of operations. For example, ten times x is a scale-by-four add of x to itself followed by a shift left of one. The same fused operations compute the byte address of a 2-, 4- or 8-byte array element from an index and a base in one step.

Operands come from a small register file. Each operation names two source registers and one destination. The result appears on the outputs one cycle after the operation is issued, and it is written into the destination register at the same clock edge, so the next operation can use it at once. A separate load port fills registers with starting values. Besides the result, the block reports a zero flag and the carry out of its adder.

Top module: `scaled_add_alu`

## Requirements
- R1: Opcode 0 (add) gives a + b modulo 2^32. The carry flag is the carry out of bit 31.
- R2: Opcode 1 (subtract) gives a - b modulo 2^32. The carry flag is 1 exactly when a >= b as unsigned numbers.
- R3: Opcode 2 (shift left) gives a shifted left by the value in b[4:0], with zeros filled in. The carry flag is 0.
- R4: Opcode 3 (negate) gives 0 - a modulo 2^32. The carry flag is 1 exactly when a is zero.
- R5: Opcodes 4, 5 and 6 give (a << N) + b modulo 2^32 for N = 1, 2 and 3. Bits shifted past bit 31 are discarded. The carry flag is the carry of the addition only.
- R6: Opcode 7 is reserved. It gives a result of 0, carry 0 and zero flag 1.
- R7: res_valid is high for exactly the cycle after a cycle with in_valid high. res_data and the flags change only then and hold their value otherwise.
- R8: Whenever res_valid is high, res_zero is 1 exactly when res_data is 0.
- R9: Each issued result is written into register rd_idx at the edge where it appears on res_data, so the next operation reads it. Chains of operations therefore give constant products such as x*3, x*5, x*9, x*10 and x*-7.
- R10: When ld_valid is high, ld_data is written into register ld_idx. If an issued result targets the same register in the same cycle, the result is stored and the load is dropped.
- R11: While rst_n is low, all outputs are 0 and every register reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue an operation this cycle |
| op | input | 3 | Operation code (0 add, 1 sub, 2 shl, 3 neg, 4/5/6 scale-add by 1/2/3, 7 reserved) |
| ra_idx | input | 3 | Register index of operand a |
| rb_idx | input | 3 | Register index of operand b |
| rd_idx | input | 3 | Destination register index |
| ld_valid | input | 1 | Load ld_data into a register |
| ld_idx | input | 3 | Register index for the load |
| ld_data | input | 32 | Load value |
| res_valid | output | 1 | Result strobe, one cycle after issue |
| res_data | output | 32 | Registered result |
| res_zero | output | 1 | Result is zero |
| res_carry | output | 1 | Adder carry out |

## Verification
Single operations run from a vector table.

- **Carry cases:** some operand pairs produce a carry out of the adder and some do not. Zero and all-ones operands are included.
- **Shift boundaries:** for the scale-add operations, some operands lose high bits to the shift. This separates discarded shift bits from a real adder carry.
- **Shift amount:** shift amounts above 31 check that only b[4:0] is used.
- **Constant multiplies:** multiply chains are run for small values, negative values and the most negative value, and are compared with a product computed in the bench. These catch a wrong shift amount per opcode and a broken write-back path.
- **Directed tests:** separate tests cover the load/write-back collision, result hold on idle cycles and reset in the middle of a run.

// File: rtl/scaled_add_pkg.sv
package scaled_add_pkg;

  localparam int ALU_W   = 32;
  localparam int SHAMT_W = $clog2(ALU_W);

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_SHL   = 3'd2,
    OP_NEG   = 3'd3,
    OP_SC1   = 3'd4,
    OP_SC2   = 3'd5,
    OP_SC3   = 3'd6,
    OP_RSVD  = 3'd7
  } alu_op_e;

  // left shift by a scale factor; bits beyond the top are dropped
  function automatic logic [ALU_W-1:0] scale_left(input logic [ALU_W-1:0] v,
                                                  input logic [1:0] n);
    return v << n;
  endfunction

  // one adder with carry in; returns {carry, sum}
  function automatic logic [ALU_W:0] add_carry(input logic [ALU_W-1:0] x,
                                               input logic [ALU_W-1:0] y,
                                               input logic cin);
    return {1'b0, x} + {1'b0, y} + {{ALU_W{1'b0}}, cin};
  endfunction

  // scale amount encoded in the fused opcodes
  function automatic logic [1:0] scale_of(input alu_op_e o);
    case (o)
      OP_SC1:  return 2'd1;
      OP_SC2:  return 2'd2;
      OP_SC3:  return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/scaled_add_regfile.sv
module scaled_add_regfile
  import scaled_add_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_a_idx,
  input  logic [IDX_W-1:0] rd_b_idx,
  output logic [ALU_W-1:0] rd_a_data,
  output logic [ALU_W-1:0] rd_b_data,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [ALU_W-1:0] wb_data,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [ALU_W-1:0] ld_data
);

  logic [ALU_W-1:0] rf_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic             hit_wb;
    logic             hit_ld;
    logic [ALU_W-1:0] q;
    assign hit_wb = wb_en && (wb_idx == IDX_W'(g));
    assign hit_ld = ld_en && (ld_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (hit_wb) q <= wb_data;   // write-back wins over load
      else if (hit_ld) q <= ld_data;
    end
    assign rf_q[g] = q;
  end

  assign rd_a_data = rf_q[rd_a_idx];
  assign rd_b_data = rf_q[rd_b_idx];

  // R9: a write-back lands in its register
  p_wb_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> rf_q[$past(wb_idx)] == $past(wb_data));

  // R10: a load with no colliding write-back lands
  p_load_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !(wb_en && wb_idx == ld_idx)) |=> rf_q[$past(ld_idx)] == $past(ld_data));

endmodule

// File: rtl/scaled_add_exec.sv
module scaled_add_exec
  import scaled_add_pkg::*;
(
  input  alu_op_e          op,
  input  logic [ALU_W-1:0] opnd_a,
  input  logic [ALU_W-1:0] opnd_b,
  output logic [ALU_W-1:0] result,
  output logic             carry,
  output logic             uses_adder,
  output logic [ALU_W-1:0] scaled_a
);

  logic [ALU_W-1:0] add_x, add_y;
  logic             add_cin;
  logic [ALU_W:0]   add_sum;
  logic [ALU_W-1:0] shl_out;

  assign scaled_a = scale_left(opnd_a, scale_of(op));
  assign shl_out  = opnd_a << opnd_b[SHAMT_W-1:0];

  always_comb begin
    add_x      = opnd_a;
    add_y      = opnd_b;
    add_cin    = 1'b0;
    uses_adder = 1'b1;
    case (op)
      OP_ADD: ;
      OP_SUB: begin add_y = ~opnd_b; add_cin = 1'b1; end
      OP_NEG: begin add_x = '0; add_y = ~opnd_a; add_cin = 1'b1; end
      OP_SC1, OP_SC2, OP_SC3: add_x = scaled_a;
      default: uses_adder = 1'b0;
    endcase
  end

  assign add_sum = add_carry(add_x, add_y, add_cin);

  always_comb begin
    if (uses_adder) begin
      result = add_sum[ALU_W-1:0];
      carry  = add_sum[ALU_W];
    end else if (op == OP_SHL) begin
      result = shl_out;
      carry  = 1'b0;
    end else begin
      result = '0;
      carry  = 1'b0;
    end
  end

endmodule

// File: rtl/scaled_add_alu.sv
module scaled_add_alu
  import scaled_add_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [2:0]       op,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [IDX_W-1:0] rb_idx,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             ld_valid,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [ALU_W-1:0] ld_data,
  output logic             res_valid,
  output logic [ALU_W-1:0] res_data,
  output logic             res_zero,
  output logic             res_carry
);

  alu_op_e          op_e;
  logic [ALU_W-1:0] opnd_a, opnd_b;
  logic [ALU_W-1:0] exec_result;
  logic             exec_carry;
  logic             exec_uses_adder;
  logic [ALU_W-1:0] exec_scaled_a;

  assign op_e = alu_op_e'(op);

  scaled_add_regfile #(.NUM_REGS(NUM_REGS)) rf_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_a_idx (ra_idx),
    .rd_b_idx (rb_idx),
    .rd_a_data(opnd_a),
    .rd_b_data(opnd_b),
    .wb_en    (in_valid),
    .wb_idx   (rd_idx),
    .wb_data  (exec_result),
    .ld_en    (ld_valid),
    .ld_idx   (ld_idx),
    .ld_data  (ld_data)
  );

  scaled_add_exec exec_i (
    .op        (op_e),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .result    (exec_result),
    .carry     (exec_carry),
    .uses_adder(exec_uses_adder),
    .scaled_a  (exec_scaled_a)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_zero  <= 1'b0;
      res_carry <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_data  <= exec_result;
        res_zero  <= (exec_result == '0);
        res_carry <= exec_carry;
      end
    end
  end

  // R7: strobe follows issue by one cycle
  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  // R7: idle cycle leaves outputs untouched
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!res_valid && $stable(res_data) && $stable(res_carry)));
  // R8: zero flag consistent with the data
  p_zero_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_zero == (res_data == '0)));
  // R6: reserved code yields zero
  p_reserved_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd7) |=> (res_data == '0 && !res_carry && res_zero));
  // R3: shift never reports a carry
  p_shl_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd2) |=> !res_carry);
  // R4: negate carries only for a zero operand
  p_neg_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd3) |=> (res_carry == ($past(opnd_a) == '0)));
  // R5: fused op with zero b returns the scaled operand
  p_scale_zero_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op >= 3'd4 && op <= 3'd6 && opnd_b == '0) |=>
      (res_data == $past(exec_scaled_a) && !res_carry));

endmodule

// File: tb/scaled_add_alu_tb.sv
module scaled_add_alu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [2:0]  ra_idx = 3'd0, rb_idx = 3'd0, rd_idx = 3'd0;
  logic        ld_valid = 1'b0;
  logic [2:0]  ld_idx = 3'd0;
  logic [31:0] ld_data = '0;
  logic        res_valid;
  logic [31:0] res_data;
  logic        res_zero;
  logic        res_carry;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  scaled_add_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .ra_idx(ra_idx), .rb_idx(rb_idx), .rd_idx(rd_idx),
    .ld_valid(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data),
    .res_valid(res_valid), .res_data(res_data),
    .res_zero(res_zero), .res_carry(res_carry)
  );

  localparam int NV = 16;
  localparam logic [2:0]  V_OP [NV] = '{3'd0, 3'd0, 3'd1, 3'd1, 3'd2, 3'd2, 3'd3, 3'd3,
                                        3'd4, 3'd5, 3'd6, 3'd6, 3'd4, 3'd4, 3'd7, 3'd1};
  localparam logic [31:0] V_A  [NV] = '{32'd5, 32'hFFFFFFFF, 32'd10, 32'd3, 32'd1, 32'h80000001,
                                        32'd5, 32'd0, 32'd3, 32'd3, 32'd3, 32'h20000001,
                                        32'h80000000, 32'h7FFFFFFF, 32'd5, 32'd5};
  localparam logic [31:0] V_B  [NV] = '{32'd7, 32'd1, 32'd3, 32'd10, 32'd4, 32'h21,
                                        32'd0, 32'd0, 32'd4, 32'd4, 32'd4, 32'd0,
                                        32'd5, 32'd2, 32'd9, 32'd5};
  localparam logic [31:0] V_R  [NV] = '{32'd12, 32'd0, 32'd7, 32'hFFFFFFF9, 32'd16, 32'd2,
                                        32'hFFFFFFFB, 32'd0, 32'd10, 32'd16, 32'd28, 32'd8,
                                        32'd5, 32'd0, 32'd0, 32'd0};
  localparam logic        V_C  [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
                                        1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  function automatic string req_of(input logic [2:0] o);
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd7: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk);
    ld_valid = 1'b1; ld_idx = idx; ld_data = val;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic exec(input logic [2:0] o, input logic [2:0] a, input logic [2:0] b,
                      input logic [2:0] d);
    @(negedge clk);
    in_valid = 1'b1; op = o; ra_idx = a; rb_idx = b; rd_idx = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic mul_chains(input logic [31:0] x);
    load(3'd1, x);
    exec(3'd4, 3'd1, 3'd1, 3'd2); chk("R9 x*3", res_data, x * 32'd3);
    exec(3'd5, 3'd1, 3'd1, 3'd2); chk("R9 x*5", res_data, x * 32'd5);
    exec(3'd6, 3'd1, 3'd1, 3'd2); chk("R9 x*9", res_data, x * 32'd9);
    exec(3'd5, 3'd1, 3'd1, 3'd2);
    exec(3'd2, 3'd2, 3'd5, 3'd3); chk("R9 x*10", res_data, x * 32'd10);
    exec(3'd2, 3'd1, 3'd6, 3'd2);
    exec(3'd1, 3'd1, 3'd2, 3'd3); chk("R9 x*-7", res_data, x * 32'hFFFFFFF9);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    // R11: outputs in reset
    chk("R11 valid", {31'd0, res_valid}, 32'd0);
    chk("R11 data", res_data, 32'd0);
    rst_n = 1'b1;
    exec(3'd0, 3'd1, 3'd2, 3'd3);
    chk("R11 regs clear", res_data, 32'd0);

    // table of single operations
    for (int i = 0; i < NV; i++) begin
      load(3'd1, V_A[i]);
      load(3'd2, V_B[i]);
      exec(V_OP[i], 3'd1, 3'd2, 3'd3);
      chk({req_of(V_OP[i]), " data"}, res_data, V_R[i]);
      chk({req_of(V_OP[i]), " carry"}, {31'd0, res_carry}, {31'd0, V_C[i]});
      chk("R8 zero", {31'd0, res_zero}, {31'd0, V_R[i] == 32'd0});
      chk("R7 valid", {31'd0, res_valid}, 32'd1);
    end

    // R7: idle cycle holds result, strobe drops
    held = res_data;
    @(negedge clk);
    op = 3'd3; ra_idx = 3'd0;
    @(negedge clk);
    chk("R7 idle valid", {31'd0, res_valid}, 32'd0);
    chk("R7 idle hold", res_data, held);

    // R9: multiply chains
    load(3'd5, 32'd1);
    load(3'd6, 32'd3);
    mul_chains(32'd7);
    mul_chains(32'hFFFFFFFD);
    mul_chains(32'h80000000);
    mul_chains(32'h12345678);

    // R10: load alone, then collision with write-back
    load(3'd4, 32'h55);
    exec(3'd0, 3'd4, 3'd0, 3'd7);
    chk("R10 load", res_data, 32'h55);
    load(3'd1, 32'd5);
    load(3'd2, 32'd7);
    @(negedge clk);
    in_valid = 1'b1; op = 3'd0; ra_idx = 3'd1; rb_idx = 3'd2; rd_idx = 3'd3;
    ld_valid = 1'b1; ld_idx = 3'd3; ld_data = 32'hAAAA;
    @(negedge clk);
    in_valid = 1'b0; ld_valid = 1'b0;
    exec(3'd0, 3'd3, 3'd0, 3'd7);
    chk("R10 wb wins", res_data, 32'd12);

    // R11: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 mid data", res_data, 32'd0);
    rst_n = 1'b1;
    exec(3'd0, 3'd1, 3'd2, 3'd3);
    chk("R11 mid regs", res_data, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule